// File: doc/BRIEF.md
# SD SPI Command Framer

This block sends one memory-card command over a byte-wide serial link and returns the card's one-byte status reply. A client gives a 6-bit command number and a 32-bit argument with a single-cycle `start`. The block sends a seven-byte frame. The frame opens with an idle filler byte and closes with a checksum byte whose CRC7 is computed in hardware while the frame goes out. The block then keeps clocking out filler bytes to poll the card until a status byte arrives or the poll budget is used up.

Each byte goes through an exchange port. The block raises `xfer_req` with the byte on `xfer_tx` and holds both until the link returns `xfer_ack`, with the byte received in exchange on `xfer_rx` in the same cycle. Bit-level shifting and clock selection belong to the link behind that port.

When the command ends, `done` pulses for one cycle. The status byte and three error flags stay valid until the next command finishes. The flags are: no card answered, the card saw a command checksum error, and any other error.

The controller has four states:
- `ST_IDLE`: waiting; `start` moves to `ST_SEND`.
- `ST_SEND`: one frame byte per acknowledge; the acknowledge of the last byte moves to `ST_POLL`.
- `ST_POLL`: filler bytes; an accepted reply or the last permitted poll moves to `ST_FIN`.
- `ST_FIN`: one cycle with `done` high, then back to `ST_IDLE`.

Top module: `sd_cmd_framer`

## Requirements
- R1: Frame bytes go out in this order: byte 0 is 0xFF, byte 1 is 0x40 OR the 6-bit command number, and bytes 2 to 5 are the argument, most significant byte first.
- R2: Byte 6 of the frame is {crc, 1'b1}. `crc` is the 7-bit CRC with polynomial x^7+x^3+1, starting from zero, over frame bytes 1 to 5, each byte taken MSB first. Command 0 with argument 0 gives 0x95. Command 8 with argument 0x000001AA gives 0x87.
- R3: Every poll byte sent is 0xFF. The first byte received during polling is never taken as the reply, even when its bit 7 is 0.
- R4: Polling stops at the first received byte after the first one whose bit 7 is 0, and `r1` takes that byte.
- R5: At most POLL_LIMIT (default 8) poll bytes are exchanged. If none is accepted, `r1` takes the last byte received.
- R6: When `r1` is 0xFF, `no_card` is 1 and the other two flags are 0.
- R7: When `r1` is not 0xFF and bit 3 of `r1` is 1, `crc_err` is 1 and the other two flags are 0.
- R8: Otherwise, `other_err` is 1 exactly when any of bits 7..1 of `r1` is set. An `r1` of 0x00 or 0x01 raises no flag. At most one flag is ever high.
- R9: While `xfer_req` is high and `xfer_ack` is low, `xfer_req` stays high and `xfer_tx` does not change. Each acknowledge moves to the next byte.
- R10: `done` is high for exactly one cycle per command. `r1` and the flags change only in that cycle and hold between commands. After reset they are 0.
- R11: `start` is ignored unless the block is idle. `xfer_req` stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_idx | input | 6 | Command number |
| cmd_arg | input | 32 | Command argument |
| xfer_req | output | 1 | Byte exchange request |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange complete |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Status byte of the last command |
| no_card | output | 1 | No reply (status 0xFF) |
| crc_err | output | 1 | Card reported a command checksum error |
| other_err | output | 1 | Any other error bit set |

## Verification
Two ways of ending the poll can fall on the same acknowledge: reaching the poll budget and accepting a reply. On the eighth poll byte both conditions are true at once. The bench provokes this in two ways. In one, the card model stays at 0xFF for seven bytes and returns 0x09 on the eighth. In the other, it returns 0x80 on the eighth. The first must be reported as an accepted reply with the checksum flag and exactly eight polls. The second falls back to the last byte and raises the other-error flag. A related overlap is a reply-like first byte. The bench returns 0x00 on the first poll byte and checks that polling goes on.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_POLL = 2'd2,
        ST_FIN  = 2'd3
    } state_t;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] CMD_PREFIX = 8'h40;
    localparam logic [6:0] CRC7_POLY  = 7'h09;

endpackage

// File: rtl/sdcf_crc7.sv
module sdcf_crc7 (
    input  logic [6:0] crc_i,
    input  logic [7:0] data_i,
    output logic [6:0] crc_o
);
    import sdcf_pkg::*;

    always_comb begin
        logic [6:0] acc;
        logic       fb;
        acc = crc_i;
        for (int b = 7; b >= 0; b--) begin
            fb  = acc[6] ^ data_i[b];
            acc = {acc[5:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC7_POLY;
            end
        end
        crc_o = acc;
    end
endmodule

// File: rtl/sdcf_frame_sel.sv
module sdcf_frame_sel #(
    parameter int IDX_BITS = 6,
    parameter int ARG_BITS = 32,
    parameter int SEL_W    = 3
) (
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [IDX_BITS-1:0] cmd_i,
    input  logic [ARG_BITS-1:0] arg_i,
    input  logic [6:0]          crc_i,
    output logic [7:0]          byte_o
);
    import sdcf_pkg::*;

    localparam int ARG_BYTES   = ARG_BITS / 8;
    localparam int FRAME_BYTES = ARG_BYTES + 3;

    logic [7:0] frame [FRAME_BYTES];

    assign frame[0] = FILL_BYTE;
    assign frame[1] = CMD_PREFIX | 8'(cmd_i);

    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
        assign frame[2+g] = arg_i[ARG_BITS-1-8*g -: 8];
    end

    assign frame[FRAME_BYTES-1] = {crc_i, 1'b1};

    always_comb begin
        byte_o = FILL_BYTE;
        for (int i = 0; i < FRAME_BYTES; i++) begin
            if (sel_i == SEL_W'(i)) begin
                byte_o = frame[i];
            end
        end
    end
endmodule

// File: rtl/sdcf_classify.sv
module sdcf_classify (
    input  logic [7:0] r1_i,
    output logic       no_card_o,
    output logic       crc_err_o,
    output logic       other_err_o
);
    always_comb begin
        no_card_o   = (r1_i == 8'hFF);
        crc_err_o   = !no_card_o && r1_i[3];
        other_err_o = !no_card_o && !r1_i[3] && (|r1_i[7:1]);
    end
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
    parameter int IDX_BITS   = 6,
    parameter int ARG_BITS   = 32,
    parameter int POLL_LIMIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IDX_BITS-1:0] cmd_idx,
    input  logic [ARG_BITS-1:0] cmd_arg,
    output logic                xfer_req,
    output logic [7:0]          xfer_tx,
    input  logic                xfer_ack,
    input  logic [7:0]          xfer_rx,
    output logic                done,
    output logic [7:0]          r1,
    output logic                no_card,
    output logic                crc_err,
    output logic                other_err
);
    import sdcf_pkg::*;

    localparam int ARG_BYTES   = ARG_BITS / 8;
    localparam int FRAME_BYTES = ARG_BYTES + 3;
    localparam int SEL_W       = $clog2(FRAME_BYTES);
    localparam int CNT_W       = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [SEL_W-1:0] LAST_SEL  = SEL_W'(FRAME_BYTES - 1);
    localparam logic [SEL_W-1:0] CRC_FIRST = SEL_W'(1);
    localparam logic [SEL_W-1:0] CRC_LAST  = SEL_W'(ARG_BYTES + 1);
    localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_LIMIT - 1);

    state_t              state_q, state_d;
    logic [SEL_W-1:0]    sel_q;
    logic [CNT_W-1:0]    poll_q;
    logic [6:0]          crc_q;
    logic [6:0]          crc_next;
    logic [IDX_BITS-1:0] cmd_q;
    logic [ARG_BITS-1:0] arg_q;
    logic [7:0]          r1_q;
    logic [7:0]          frame_byte;
    logic                reply_hit;
    logic                poll_end;

    sdcf_frame_sel #(
        .IDX_BITS (IDX_BITS),
        .ARG_BITS (ARG_BITS),
        .SEL_W    (SEL_W)
    ) u_sel (
        .sel_i  (sel_q),
        .cmd_i  (cmd_q),
        .arg_i  (arg_q),
        .crc_i  (crc_q),
        .byte_o (frame_byte)
    );

    sdcf_crc7 u_crc (
        .crc_i  (crc_q),
        .data_i (frame_byte),
        .crc_o  (crc_next)
    );

    sdcf_classify u_cls (
        .r1_i        (r1_q),
        .no_card_o   (no_card),
        .crc_err_o   (crc_err),
        .other_err_o (other_err)
    );

    assign reply_hit = (poll_q != '0) && !xfer_rx[7];
    assign poll_end  = reply_hit || (poll_q == POLL_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (xfer_ack && sel_q == LAST_SEL) state_d = ST_POLL;
            ST_POLL: if (xfer_ack && poll_end) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            poll_q <= '0;
            crc_q  <= '0;
            cmd_q  <= '0;
            arg_q  <= '0;
            r1_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q  <= cmd_idx;
                        arg_q  <= cmd_arg;
                        sel_q  <= '0;
                        poll_q <= '0;
                        crc_q  <= '0;
                    end
                end
                ST_SEND: begin
                    if (xfer_ack) begin
                        if (sel_q >= CRC_FIRST && sel_q <= CRC_LAST) begin
                            crc_q <= crc_next;
                        end
                        if (sel_q != LAST_SEL) begin
                            sel_q <= sel_q + 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (xfer_ack) begin
                        poll_q <= poll_q + 1'b1;
                        if (poll_end) begin
                            r1_q <= xfer_rx;
                        end
                    end
                end
                ST_FIN: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        xfer_req = 1'b0;
        xfer_tx  = FILL_BYTE;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SEND: begin
                xfer_req = 1'b1;
                xfer_tx  = frame_byte;
            end
            ST_POLL: begin
                xfer_req = 1'b1;
                xfer_tx  = FILL_BYTE;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign r1 = r1_q;

endmodule

// File: rtl/sd_cmd_framer_chk.sv
module sd_cmd_framer_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  xfer_req,
    input logic [7:0]            xfer_tx,
    input logic                  xfer_ack,
    input logic                  done,
    input logic [7:0]            r1,
    input logic                  no_card,
    input logic                  crc_err,
    input logic                  other_err,
    input sdcf_pkg::state_t      state_q
);
    import sdcf_pkg::*;

    p_hold_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_r1_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r1) |-> done);

    p_poll_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && xfer_req) |-> (xfer_tx == 8'hFF));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !xfer_req);

    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_POLL || state_q == ST_FIN) && start) |=> (state_q != ST_SEND));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({no_card, crc_err, other_err}));

    p_nocard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 == 8'hFF) |-> no_card);

    p_crcflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 != 8'hFF && r1[3]) |-> crc_err);

endmodule

bind sd_cmd_framer sd_cmd_framer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .xfer_req  (xfer_req),
    .xfer_tx   (xfer_tx),
    .xfer_ack  (xfer_ack),
    .done      (done),
    .r1        (r1),
    .no_card   (no_card),
    .crc_err   (crc_err),
    .other_err (other_err),
    .state_q   (state_q)
);

// File: tb/sd_cmd_framer_tb_top.sv
module sd_cmd_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;
    logic        done;
    logic [7:0]  r1;
    logic        no_card, crc_err, other_err;

    int total = 0;
    int bad   = 0;

    logic [7:0] log_tx [64];
    logic [7:0] resp   [16];
    int         n_log   = 0;
    int         ack_gap = 0;
    int         gap_cnt = 0;

    always #5 clk = ~clk;

    sd_cmd_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_idx   (cmd_idx),
        .cmd_arg   (cmd_arg),
        .xfer_req  (xfer_req),
        .xfer_tx   (xfer_tx),
        .xfer_ack  (xfer_ack),
        .xfer_rx   (xfer_rx),
        .done      (done),
        .r1        (r1),
        .no_card   (no_card),
        .crc_err   (crc_err),
        .other_err (other_err)
    );

    // card model: answers each request at a falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_ack) begin
                xfer_ack = 1'b0;
            end else if (xfer_req) begin
                if (gap_cnt < ack_gap) begin
                    gap_cnt++;
                end else begin
                    gap_cnt = 0;
                    if (n_log < 64) log_tx[n_log] = xfer_tx;
                    xfer_rx  = (n_log < 7) ? 8'hFF : resp[(n_log - 7) % 16];
                    xfer_ack = 1'b1;
                    n_log++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] bits;
        logic [6:0]  c;
        logic        fb;
        bits = {8'h40 | {2'b00, idx}, arg};
        c = '0;
        for (int b = 39; b >= 0; b--) begin
            fb = c[6] ^ bits[b];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // expected number of poll bytes for the current resp table
    function automatic int ref_polls();
        for (int k = 1; k < 8; k++) begin
            if (!resp[k][7]) return k + 1;
        end
        return 8;
    endfunction

    task automatic fill_resp(input logic [7:0] v);
        for (int k = 0; k < 16; k++) resp[k] = v;
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg);
        @(negedge clk);
        n_log   = 0;
        start   = 1'b1;
        cmd_idx = idx;
        cmd_arg = arg;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int t;
        t = 0;
        seen = done;
        while (!seen && t < 3000) begin
            @(negedge clk);
            seen = done;
            t++;
        end
    endtask

    // runs one command and checks frame, poll count, r1 and flags
    task automatic run_check(input string name, input logic [5:0] idx, input logic [31:0] arg);
        bit          seen;
        int          np;
        logic [7:0]  er1;
        logic [7:0]  held;
        issue(idx, arg);
        wait_done(seen);
        chk(seen, {name, " R10 done seen"}, 32'(seen), 1);
        np  = ref_polls();
        er1 = resp[np-1];
        chk(log_tx[0] == 8'hFF, {name, " R1 byte0"}, 32'(log_tx[0]), 32'hFF);
        chk(log_tx[1] == (8'h40 | {2'b00, idx}), {name, " R1 cmd byte"}, 32'(log_tx[1]), 32'(8'h40 | {2'b00, idx}));
        chk({log_tx[2], log_tx[3], log_tx[4], log_tx[5]} == arg, {name, " R1 argument"},
            {log_tx[2], log_tx[3], log_tx[4], log_tx[5]}, arg);
        chk(log_tx[6] == {ref_crc(idx, arg), 1'b1}, {name, " R2 crc byte"}, 32'(log_tx[6]), 32'({ref_crc(idx, arg), 1'b1}));
        chk(n_log - 7 == np, {name, " R4 R5 poll count"}, 32'(n_log - 7), 32'(np));
        for (int k = 7; k < n_log && k < 64; k++) begin
            if (log_tx[k] != 8'hFF) chk(1'b0, {name, " R3 poll byte"}, 32'(log_tx[k]), 32'hFF);
        end
        chk(r1 == er1, {name, " R4 R5 r1"}, 32'(r1), 32'(er1));
        chk(no_card == (er1 == 8'hFF), {name, " R6 no_card"}, 32'(no_card), 32'(er1 == 8'hFF));
        chk(crc_err == (er1 != 8'hFF && er1[3]), {name, " R7 crc_err"}, 32'(crc_err), 32'(er1 != 8'hFF && er1[3]));
        chk(other_err == (er1 != 8'hFF && !er1[3] && (|er1[7:1])), {name, " R8 other_err"},
            32'(other_err), 32'(er1 != 8'hFF && !er1[3] && (|er1[7:1])));
        held = r1;
        @(negedge clk);
        chk(!done, {name, " R10 done one cycle"}, 32'(done), 0);
        repeat (4) @(negedge clk);
        chk(r1 == held && !xfer_req, {name, " R10 R11 hold and quiet"}, 32'(r1), 32'(held));
    endtask

    task automatic t_reset();
        chk(r1 == 8'h00 && !done && !xfer_req, "R10 reset r1/done/req", 32'(r1), 0);
        chk(!no_card && !crc_err && !other_err, "R8 reset flags", {29'd0, no_card, crc_err, other_err}, 0);
    endtask

    task automatic t_known_crc();
        fill_resp(8'hFF);
        resp[1] = 8'h01;
        ack_gap = 0;
        run_check("cmd0", 6'd0, 32'h0);
        chk(log_tx[6] == 8'h95, "R2 cmd0 constant 0x95", 32'(log_tx[6]), 32'h95);
        fill_resp(8'hFF);
        resp[2] = 8'h05;
        run_check("cmd8", 6'd8, 32'h000001AA);
        chk(log_tx[6] == 8'h87, "R2 cmd8 constant 0x87", 32'(log_tx[6]), 32'h87);
    endtask

    task automatic t_first_discard();
        fill_resp(8'hFF);
        resp[0] = 8'h00;
        resp[2] = 8'h00;
        ack_gap = 3;
        run_check("discard_first R3", 6'd17, 32'hDEADBEEF);
        ack_gap = 0;
    endtask

    task automatic t_limit_hit();
        fill_resp(8'hFF);
        resp[7] = 8'h09;
        run_check("limit_hit R5 R7", 6'd24, 32'h12345678);
    endtask

    task automatic t_no_card();
        fill_resp(8'hFF);
        run_check("no_card R6", 6'd63, 32'hFFFFFFFF);
    endtask

    task automatic t_msb_last();
        fill_resp(8'hFF);
        resp[7] = 8'h80;
        run_check("msb_last R8", 6'd55, 32'h00000000);
    endtask

    task automatic t_other();
        fill_resp(8'hFF);
        resp[3] = 8'h40;
        ack_gap = 1;
        run_check("param_err R8", 6'd12, 32'hA5A55A5A);
        ack_gap = 0;
    endtask

    task automatic t_busy_start();
        bit seen;
        int t;
        fill_resp(8'hFF);
        resp[5] = 8'h00;
        ack_gap = 2;
        issue(6'd9, 32'h01020304);
        t = 0;
        while (n_log < 8 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        start   = 1'b1;
        cmd_idx = 6'd33;
        @(negedge clk);
        start   = 1'b0;
        wait_done(seen);
        chk(seen && r1 == 8'h00, "R11 busy start r1", 32'(r1), 0);
        chk(n_log == 13, "R11 busy start byte count", 32'(n_log), 13);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(n_log == 13 && !xfer_req, "R11 start in done cycle ignored", 32'(n_log), 13);
        ack_gap = 0;
    endtask

    initial begin
        fill_resp(8'hFF);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_crc();
        t_first_discard();
        t_limit_hit();
        t_no_card();
        t_msb_last();
        t_other();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule